// File: doc/BRIEF.md
# Memory-Driven JTAG Stream Player

This block plays a prepared JTAG waveform image out of a byte-wide nonvolatile memory and onto a JTAG chain. The block does not track the TAP state. Each stored byte packs four test clocks, with two bits for each clock: one for TMS and one for the serial data sent toward the chain. A four-byte little-endian header at the base of the memory gives the address one past the last stream byte. The stream itself starts at byte 4.

Every reset starts a fresh download, including power-up and a reset applied partway through a download. While the download runs, the block holds the target system in reset, enables the memory and lights the status LED. When the last clock has been played, it releases the target, disables the memory and turns off the LED. It then raises `done` and stays idle until the next reset.

Two parameters set the timing. `DIV` is the length, in system clocks, of each TCK phase. `RD_LAT` is the fixed read latency of the memory.

Top module: `jtag_image_player`

## Requirements
- R1: For each stream byte, clock k (k = 0..3) drives `jtag_sdo` = bit 2k and `jtag_tms` = bit 2k+1, with no inversion. The four clocks are issued in increasing k.
- R2: The end address E is read from addresses 0..3, least significant byte at address 0. Bytes are then read from address 4 up to E-1 in increasing order, and exactly 4·(E-4) TCK rising edges are issued. No address above max(E-1, 3) is presented while the memory is enabled.
- R3: While `rst_n` is low the outputs are as follows: `jtag_tck` low, `tgt_rst_n` low, `mem_ce_n` low, `led_on` high and `done` low.
- R4: Every TCK high phase lasts exactly `DIV` clocks. TMS and data stay unchanged for at least `DIV` clocks of TCK low before each rising edge. TMS and data never change while TCK is high.
- R5: After the address changes, the byte on `mem_data` is taken `RD_LAT`+1 clocks later. The memory is expected to present the byte at `mem_addr` `RD_LAT` clocks after that address appears.
- R6: If E is 4 or less, no TCK pulse is issued and the block completes directly.
- R7: On completion `tgt_rst_n`, `mem_ce_n` and `done` go high and `led_on` goes low. All four hold until the next reset, TCK stays low and no further pulses occur.
- R8: A reset applied in the middle of a download returns the outputs to the R3 state. After that reset the full stream is replayed from the header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, starts a download |
| mem_addr | output | ADDR_W | Byte read address |
| mem_data | input | 8 | Read data, valid RD_LAT clocks after the address |
| mem_ce_n | output | 1 | Active-low memory enable |
| jtag_tck | output | 1 | Test clock |
| jtag_tms | output | 1 | Test mode select |
| jtag_sdo | output | 1 | Serial data toward the chain |
| tgt_rst_n | output | 1 | Active-low reset to the target system |
| led_on | output | 1 | Status LED, high while downloading |
| done | output | 1 | Download finished |

## Verification
The bench builds the block with `DIV`=2, `RD_LAT`=3 and `ADDR_W`=10. With `DIV` above one, the exact length of each high phase and the minimum length of each low phase can be told apart from the one-clock case. With `RD_LAT` above one, a byte taken too early yields wrong pairs on the chain. The 10-bit address space allows a header of 0x106. Because that header has a nonzero second byte, it exposes any swap of header byte order and shows wraps of the header index while staying short. Empty and below-four headers, all-zero and all-one bytes, and a reset applied mid-stream are also played.

// File: rtl/jtag_image_player.sv
module jtag_image_player #(
  parameter int ADDR_W = 16,
  parameter int DIV    = 4,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic              mem_ce_n,
  output logic              jtag_tck,
  output logic              jtag_tms,
  output logic              jtag_sdo,
  output logic              tgt_rst_n,
  output logic              led_on,
  output logic              done
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WW = $clog2(RD_LAT + 1);

  typedef enum logic [1:0] {S_HDR, S_FETCH, S_SHIFT, S_DONE} st_t;
  st_t st;

  logic [ADDR_W-1:0] ptr;
  logic [WW-1:0]     wcnt;
  logic [DW-1:0]     dcnt;
  logic [31:0]       end_r;
  logic [7:0]        sh;
  logic [1:0]        pi;
  logic [31:0]       hdr_end;
  logic [31:0]       nxt_addr;

  assign mem_addr = ptr;
  assign hdr_end  = {mem_data, end_r[23:0]};
  assign nxt_addr = 32'(ptr) + 32'd1;
  assign jtag_tms = sh[{pi, 1'b1}];
  assign jtag_sdo = sh[{pi, 1'b0}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_HDR;
      ptr       <= '0;
      wcnt      <= WW'(RD_LAT);
      dcnt      <= '0;
      end_r     <= '0;
      sh        <= '0;
      pi        <= '0;
      jtag_tck  <= 1'b0;
      tgt_rst_n <= 1'b0;
      mem_ce_n  <= 1'b0;
      led_on    <= 1'b1;
      done      <= 1'b0;
    end else begin
      case (st)
        S_HDR: begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else begin
            end_r[{ptr[1:0], 3'b000} +: 8] <= mem_data;
            if (ptr[1:0] == 2'd3 && hdr_end <= 32'd4) st <= S_DONE;
            else begin
              ptr  <= ptr + 1'b1;
              wcnt <= WW'(RD_LAT);
              if (ptr[1:0] == 2'd3) st <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (wcnt != '0) wcnt <= wcnt - 1'b1;
          else begin
            sh   <= mem_data;
            pi   <= 2'd0;
            dcnt <= '0;
            st   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (dcnt != DW'(DIV - 1)) dcnt <= dcnt + 1'b1;
          else begin
            dcnt <= '0;
            if (!jtag_tck) jtag_tck <= 1'b1;
            else begin
              jtag_tck <= 1'b0;
              if (pi != 2'd3) pi <= pi + 1'b1;
              else if (nxt_addr >= end_r) st <= S_DONE;
              else begin
                ptr  <= ptr + 1'b1;
                wcnt <= WW'(RD_LAT);
                st   <= S_FETCH;
              end
            end
          end
        end
        default: begin
          tgt_rst_n <= 1'b1;
          mem_ce_n  <= 1'b1;
          led_on    <= 1'b0;
          done      <= 1'b1;
        end
      endcase
    end
  end

  // R4
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({jtag_tms, jtag_sdo}) |-> !jtag_tck);
  // R4
  tck_rise_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jtag_tck) |-> $past(st) == S_SHIFT);
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !jtag_tck);
  // R7
  done_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tgt_rst_n && mem_ce_n && !led_on);
  // R3
  busy_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_DONE |-> !tgt_rst_n && !mem_ce_n && led_on && !done);
  // R6
  short_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && wcnt == '0 && ptr[1:0] == 2'd3 && hdr_end <= 32'd4) |=> st == S_DONE && !jtag_tck);
endmodule

// File: tb/sim_jtag_image_player.sv
module sim_jtag_image_player;
  localparam int ADDR_W = 10;
  localparam int DIV    = 2;
  localparam int RD_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data;
  logic mem_ce_n, jtag_tck, jtag_tms, jtag_sdo, tgt_rst_n, led_on, done;

  always #5 clk = ~clk;

  jtag_image_player #(.ADDR_W(ADDR_W), .DIV(DIV), .RD_LAT(RD_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ce_n(mem_ce_n), .jtag_tck(jtag_tck), .jtag_tms(jtag_tms),
    .jtag_sdo(jtag_sdo), .tgt_rst_n(tgt_rst_n), .led_on(led_on), .done(done));

  logic [7:0] mem [0:(1<<ADDR_W)-1];
  logic [7:0] pipe [0:RD_LAT-1];
  always_ff @(posedge clk) begin
    pipe[0] <= mem[mem_addr];
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign mem_data = pipe[RD_LAT-1];

  int vecs = 0, fails = 0;
  logic [1:0] q [$];
  int lim = 3, viol = 0, rises = 0, exp_rises = 0;

  // R1 / R2: scoreboard monitor on each rising TCK edge
  always @(posedge jtag_tck) begin
    rises++;
    vecs++;
    if (q.size() == 0) begin
      fails++;
      $display("FAIL R7 extra TCK pulse: got tms/sdo=%b%b expected none", jtag_tms, jtag_sdo);
    end else begin
      logic [1:0] e;
      e = q.pop_front();
      if ({jtag_tms, jtag_sdo} !== e || tgt_rst_n !== 1'b0) begin
        fails++;
        $display("FAIL R1 tms/sdo=%b%b rst_n=%b expected %b rst_n=0",
                 jtag_tms, jtag_sdo, tgt_rst_n, e);
      end
    end
  end

  int hcnt = 0, lcnt = 0;
  logic [1:0] ppair = 2'b00;
  logic ptck = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      hcnt = 0; lcnt = 0; ptck = 1'b0; ppair = {jtag_tms, jtag_sdo};
    end else begin
      if (!mem_ce_n && int'(mem_addr) > lim) viol++;
      if (jtag_tck) begin
        if (!ptck) begin
          vecs++;
          if (lcnt < DIV) begin
            fails++;
            $display("FAIL R4 low setup %0d clocks, expected >= %0d", lcnt, DIV);
          end
        end
        if ({jtag_tms, jtag_sdo} != ppair) begin
          fails++;
          $display("FAIL R4 pair changed while TCK high: %b expected %b", {jtag_tms, jtag_sdo}, ppair);
        end
        hcnt++;
      end else begin
        if (ptck) begin
          vecs++;
          if (hcnt != DIV) begin
            fails++;
            $display("FAIL R4 high phase %0d clocks, expected %0d", hcnt, DIV);
          end
          hcnt = 0;
        end
        if ({jtag_tms, jtag_sdo} != ppair) lcnt = 1; else lcnt++;
      end
      ptck = jtag_tck;
      ppair = {jtag_tms, jtag_sdo};
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int a, int seed);
    if (seed == 1 && a == 4) return 8'h00;
    if (seed == 1 && a == 5) return 8'hFF;
    if (seed == 1 && a == 6) return 8'hA5;
    return 8'((a * 29) ^ (seed * 71) ^ (a >> 3));
  endfunction

  // driver: fill memory and push the expected pairs
  task automatic load(int endv, int seed);
    q.delete();
    for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = pat(a, seed);
    mem[0] = endv[7:0]; mem[1] = endv[15:8]; mem[2] = endv[23:16]; mem[3] = endv[31:24];
    exp_rises = 0;
    for (int a = 4; a < endv; a++)
      for (int k = 0; k < 4; k++) begin
        q.push_back({mem[a][2*k+1], mem[a][2*k]});
        exp_rises++;
      end
    lim = (endv > 4) ? endv - 1 : 3;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R3 reset state
    check("R3 tck", 32'(jtag_tck), 0);
    check("R3 tgt_rst_n", 32'(tgt_rst_n), 0);
    check("R3 ce_n/led/done", {29'd0, mem_ce_n, led_on, done}, 32'b010);
    viol = 0; rises = 0;
    rst_n = 1'b1;
  endtask

  task automatic finish_run(string name);
    int t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    if (!done) begin
      fails++;
      $display("FAIL R7 %s watchdog: done never rose", name);
    end
    repeat (40) @(negedge clk);
    // R7 completion outputs
    check("R7 outputs", {28'd0, tgt_rst_n, mem_ce_n, led_on, done}, 32'b1101);
    check("R7 tck low", 32'(jtag_tck), 0);
    // R2 stream length and address range
    check("R2 pulses", 32'(rises), 32'(exp_rises));
    check("R2 leftover", 32'(q.size()), 0);
    check("R2 addr range", 32'(viol), 0);
  endtask

  initial begin
    load(4, 0); do_reset(); finish_run("empty");                 // R6 E=4
    load(2, 0); do_reset(); finish_run("short");                 // R6 E<4
    load(7, 1); do_reset(); finish_run("fixed bytes");           // R1 00/FF/A5
    load(20, 2); do_reset(); finish_run("mixed");                // R5 latency
    load(32'h106, 3); do_reset(); finish_run("long le header");  // R2 byte order
    // R8 reset mid-stream, then full replay
    load(30, 4); do_reset();
    while (rises < 21) @(negedge clk);
    load(30, 4); do_reset();
    finish_run("replay");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL R7 global watchdog expired: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule